// File: doc/BRIEF.md
# GPIO Bank with Edge Interrupts

This block is a bank of general-purpose pins, configurable from 1 to 64 pins, that software reaches through a plain 32-bit register port with a byte address. Each pin's state is split over a low word (pins 0 to 31) and a high word (pins 32 to 63). Per pin it holds a direction bit, a drive value and a synchronized copy of the pin level.

A second register window holds the interrupt state. Each pin has an enable bit, a single edge-polarity bit, a sticky pending flag and a wake-enable bit. Every input passes two synchronizing flops before edge detection. A detected edge sets the pending flag, and software clears it by writing 1. The interrupt line is raised while any pending flag with its enable set is present. The wake line is raised while any pending flag with its wake bit set is present, whatever the enable bits hold.

The block has no both-edge mode. To catch both edges of a signal, software flips the pin's polarity bit after each event.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset every register reads zero, `pin_oe` and `pin_out` are all zero, and `irq` and `wake` are low.
- R2: The direction word sits at byte offset 0x00 (low) and 0x04 (high). Bit value 1 makes the pin an output on `pin_oe` from the clock after the write, and bit value 0 makes it an input. Reading the word returns the direction.
- R3: The drive-value word sits at 0x18 (low) and 0x1C (high). It drives `pin_out` from the clock after the write and reads back as written.
- R4: The input word sits at 0x10 (low) and 0x14 (high). It returns each pin's level as it stood two rising clock edges after the pin changed. Writes to this word have no effect.
- R5: Pin n maps to bit n of the low word for n < 32, and to bit n-32 of the word 4 bytes higher otherwise. Bits for pins at or above NUM_PINS read 0 and ignore writes.
- R6: The interrupt window uses these offsets: enable at 0x40/0x44, polarity at 0x48/0x4C, pending at 0x50/0x54, wake enable at 0x58/0x5C. Polarity value 0 detects a rising edge and value 1 a falling edge. The pending bit is set at the third rising clock edge after the pin changes. An edge of the other direction sets nothing.
- R7: Pending bits are sticky. Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. When an edge is detected in the same cycle as a clearing write to that bit, the bit stays set. A pending bit is never set without a detected edge.
- R8: `irq` is high exactly when some pin has both its pending and its enable bit set. A pending bit still latches while its enable bit is clear.
- R9: `wake` is high exactly when some pin has both its pending and its wake-enable bit set, independently of the enable bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 7 | Byte address; bit 2 picks the high word, bits 1:0 are ignored |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NUM_PINS | Pin levels from the pads, asynchronous |
| pin_out | output | NUM_PINS | Drive value per pin |
| pin_oe | output | NUM_PINS | Output enable per pin, 1 = output |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake request |

## Verification
On every cycle the assertions check these rules: pending flags never drop without a clearing write, a newly set pending flag always has a detected edge behind it, the interrupt stays low with all enables clear, and the wake line needs a pending flag. They also check that a low direction-word write appears on `pin_oe` one clock later. The bench scenarios show what no single-cycle property shows. These are the exact two-edge latency through the synchronizer, polarity selection on both words, a clearing write that meets a new edge in the same cycle, software flipping the polarity to catch the opposite edge, the write-ignore of the input word, and wake raised by a pin whose interrupt is disabled.

// File: rtl/gpio_edge_bank_pkg.sv
`timescale 1ns/1ps
package gpio_edge_bank_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 7;

    // register slot = bus_addr[6:3]; bus_addr[2] picks the high word
    localparam logic [3:0] SLOT_DIR   = 4'h0;
    localparam logic [3:0] SLOT_LVL   = 4'h2;
    localparam logic [3:0] SLOT_DRV   = 4'h3;
    localparam logic [3:0] SLOT_IEN   = 4'h8;
    localparam logic [3:0] SLOT_IPOL  = 4'h9;
    localparam logic [3:0] SLOT_IPEND = 4'hA;
    localparam logic [3:0] SLOT_IWAKE = 4'hB;

    // one two-bit lane mask (bit0 low word, bit1 high word) per writable word
    typedef struct packed {
        logic [1:0] dir;
        logic [1:0] drv;
        logic [1:0] ien;
        logic [1:0] ipol;
        logic [1:0] iclr;
        logic [1:0] iwake;
    } wr_lanes_t;

endpackage

// File: rtl/gpio_in_stage.sv
`timescale 1ns/1ps
module gpio_in_stage #(
    parameter int NUM_PINS = 36
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NUM_PINS-1:0] pol,
    output logic [NUM_PINS-1:0] level,
    output logic [NUM_PINS-1:0] edge_hit
);

    typedef struct packed {
        logic [NUM_PINS-1:0] meta;
        logic [NUM_PINS-1:0] sync;
        logic [NUM_PINS-1:0] last;
    } in_state_t;

    in_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = pin_in;
        st_d.sync = st_q.meta;
        st_d.last = st_q.sync;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (pol[i]) begin
                edge_hit[i] = st_q.last[i] & ~st_q.sync[i];
            end else begin
                edge_hit[i] = st_q.sync[i] & ~st_q.last[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.sync;

endmodule

// File: rtl/gpio_out_regs.sv
`timescale 1ns/1ps
module gpio_out_regs
    import gpio_edge_bank_pkg::*;
#(
    parameter int NUM_PINS = 36
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          dir_we,
    input  logic [1:0]          drv_we,
    input  logic [WORD_W-1:0]   wdata,
    output logic [NUM_PINS-1:0] dir_q,
    output logic [NUM_PINS-1:0] drv_q
);

    typedef struct packed {
        logic [NUM_PINS-1:0] dir;
        logic [NUM_PINS-1:0] drv;
    } out_state_t;

    out_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (dir_we[i / WORD_W]) begin
                st_d.dir[i] = wdata[i % WORD_W];
            end
            if (drv_we[i / WORD_W]) begin
                st_d.drv[i] = wdata[i % WORD_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dir_q = st_q.dir;
    assign drv_q = st_q.drv;

endmodule

// File: rtl/gpio_irq_regs.sv
`timescale 1ns/1ps
module gpio_irq_regs
    import gpio_edge_bank_pkg::*;
#(
    parameter int NUM_PINS = 36
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          ien_we,
    input  logic [1:0]          ipol_we,
    input  logic [1:0]          iclr_we,
    input  logic [1:0]          iwake_we,
    input  logic [WORD_W-1:0]   wdata,
    input  logic [NUM_PINS-1:0] edge_hit,
    output logic [NUM_PINS-1:0] ien_q,
    output logic [NUM_PINS-1:0] ipol_q,
    output logic [NUM_PINS-1:0] ipend_q,
    output logic [NUM_PINS-1:0] iwake_q,
    output logic                irq,
    output logic                wake
);

    typedef struct packed {
        logic [NUM_PINS-1:0] en;
        logic [NUM_PINS-1:0] pol;
        logic [NUM_PINS-1:0] pend;
        logic [NUM_PINS-1:0] wk;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (ien_we[i / WORD_W]) begin
                st_d.en[i] = wdata[i % WORD_W];
            end
            if (ipol_we[i / WORD_W]) begin
                st_d.pol[i] = wdata[i % WORD_W];
            end
            if (iwake_we[i / WORD_W]) begin
                st_d.wk[i] = wdata[i % WORD_W];
            end
            // a clearing write loses to an edge in the same cycle
            if (iclr_we[i / WORD_W] && wdata[i % WORD_W]) begin
                st_d.pend[i] = 1'b0;
            end
            if (edge_hit[i]) begin
                st_d.pend[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ien_q   = st_q.en;
    assign ipol_q  = st_q.pol;
    assign ipend_q = st_q.pend;
    assign iwake_q = st_q.wk;
    assign irq     = |(st_q.pend & st_q.en);
    assign wake    = |(st_q.pend & st_q.wk);

endmodule

// File: rtl/gpio_edge_bank.sv
`timescale 1ns/1ps
module gpio_edge_bank
    import gpio_edge_bank_pkg::*;
#(
    parameter int NUM_PINS = 36
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq,
    output logic                wake
);

    localparam int BANK_W = 2 * WORD_W;

    logic [3:0]          slot;
    logic                hi_word;
    logic [1:0]          lanes;
    wr_lanes_t           wl;
    logic                unused_addr_bits;

    logic [NUM_PINS-1:0] level;
    logic [NUM_PINS-1:0] edge_hit;
    logic [NUM_PINS-1:0] ien_q;
    logic [NUM_PINS-1:0] ipol_q;
    logic [NUM_PINS-1:0] ipend_q;
    logic [NUM_PINS-1:0] iwake_q;
    logic [BANK_W-1:0]   rd_wide;

    function automatic logic [BANK_W-1:0] widen(input logic [NUM_PINS-1:0] v);
        logic [BANK_W-1:0] w;
        w = '0;
        w[NUM_PINS-1:0] = v;
        return w;
    endfunction

    assign slot             = bus_addr[6:3];
    assign hi_word          = bus_addr[2];
    assign lanes            = hi_word ? 2'b10 : 2'b01;
    assign unused_addr_bits = ^bus_addr[1:0];

    always_comb begin
        wl = '0;
        if (bus_wr) begin
            case (slot)
                SLOT_DIR:   wl.dir   = lanes;
                SLOT_DRV:   wl.drv   = lanes;
                SLOT_IEN:   wl.ien   = lanes;
                SLOT_IPOL:  wl.ipol  = lanes;
                SLOT_IPEND: wl.iclr  = lanes;
                SLOT_IWAKE: wl.iwake = lanes;
                default:    wl       = '0;
            endcase
        end
    end

    always_comb begin
        case (slot)
            SLOT_DIR:   rd_wide = widen(pin_oe);
            SLOT_LVL:   rd_wide = widen(level);
            SLOT_DRV:   rd_wide = widen(pin_out);
            SLOT_IEN:   rd_wide = widen(ien_q);
            SLOT_IPOL:  rd_wide = widen(ipol_q);
            SLOT_IPEND: rd_wide = widen(ipend_q);
            SLOT_IWAKE: rd_wide = widen(iwake_q);
            default:    rd_wide = '0;
        endcase
        bus_rdata = hi_word ? rd_wide[BANK_W-1:WORD_W] : rd_wide[WORD_W-1:0];
    end

    gpio_in_stage #(.NUM_PINS(NUM_PINS)) in_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .pol      (ipol_q),
        .level    (level),
        .edge_hit (edge_hit)
    );

    gpio_out_regs #(.NUM_PINS(NUM_PINS)) out_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .dir_we (wl.dir),
        .drv_we (wl.drv),
        .wdata  (bus_wdata),
        .dir_q  (pin_oe),
        .drv_q  (pin_out)
    );

    gpio_irq_regs #(.NUM_PINS(NUM_PINS)) irq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ien_we   (wl.ien),
        .ipol_we  (wl.ipol),
        .iclr_we  (wl.iclr),
        .iwake_we (wl.iwake),
        .wdata    (bus_wdata),
        .edge_hit (edge_hit),
        .ien_q    (ien_q),
        .ipol_q   (ipol_q),
        .ipend_q  (ipend_q),
        .iwake_q  (iwake_q),
        .irq      (irq),
        .wake     (wake)
    );

endmodule

// File: rtl/gpio_edge_bank_chk.sv
`timescale 1ns/1ps
module gpio_edge_bank_chk #(
    parameter int NUM_PINS = 36
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr,
    input logic [6:0]          bus_addr,
    input logic [31:0]         bus_wdata,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic                irq,
    input logic                wake,
    input logic [NUM_PINS-1:0] ipend_q,
    input logic [NUM_PINS-1:0] ien_q,
    input logic [NUM_PINS-1:0] edge_hit
);

    localparam int LO_W = (NUM_PINS < 32) ? NUM_PINS : 32;

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        $rose(rst_n) |-> (pin_oe == '0 && !irq && !wake));

    // R2
    a_r2_dir_write_low: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[6:2] == 5'b00000) |=> (pin_oe[LO_W-1:0] == $past(bus_wdata[LO_W-1:0])));

    // R7
    a_r7_pending_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr[6:3] == 4'hA) |=> ((ipend_q & $past(ipend_q)) == $past(ipend_q)));

    // R7
    a_r7_set_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ipend_q & ~$past(ipend_q) & ~$past(edge_hit)) == '0));

    // R8
    a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq);

    // R9
    a_r9_wake_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (ipend_q != '0));

endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(.NUM_PINS(NUM_PINS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .wake      (wake),
    .ipend_q   (ipend_q),
    .ien_q     (ien_q),
    .edge_hit  (edge_hit)
);

// File: tb/gpio_edge_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_edge_bank_tb_top;

    localparam int NP = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [6:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic          irq;
    logic          wake;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_edge_bank #(.NUM_PINS(NP)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq), .wake(wake)
    );

    // ---------------- behavioural reference model ----------------
    logic [63:0] m_ff1, m_ff2, m_old, m_dir, m_drv, m_en, m_pol, m_pend, m_wk, m_hit;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ff1 = '0; m_ff2 = '0; m_old = '0; m_dir = '0; m_drv = '0;
            m_en = '0; m_pol = '0; m_pend = '0; m_wk = '0; m_hit = '0;
        end else begin
            for (int p = 0; p < NP; p++) begin
                if (m_pol[p]) m_hit[p] = (m_old[p] == 1'b1) && (m_ff2[p] == 1'b0);
                else          m_hit[p] = (m_old[p] == 1'b0) && (m_ff2[p] == 1'b1);
            end
            if (bus_wr) begin
                for (int b = 0; b < 32; b++) begin
                    int pin;
                    pin = (bus_addr[2] ? 32 : 0) + b;
                    if (pin < NP) begin
                        case (bus_addr[6:3])
                            4'h0: m_dir[pin] = bus_wdata[b];
                            4'h3: m_drv[pin] = bus_wdata[b];
                            4'h8: m_en[pin]  = bus_wdata[b];
                            4'h9: m_pol[pin] = bus_wdata[b];
                            4'hA: if (bus_wdata[b]) m_pend[pin] = 1'b0;
                            4'hB: m_wk[pin]  = bus_wdata[b];
                            default: ;
                        endcase
                    end
                end
            end
            for (int p = 0; p < NP; p++) if (m_hit[p]) m_pend[p] = 1'b1;
            m_old = m_ff2;
            m_ff2 = m_ff1;
            m_ff1 = '0;
            m_ff1[NP-1:0] = pin_in;
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R8 irq vs model", 64'(irq), 64'(|(m_pend & m_en)));
            check("R9 wake vs model", 64'(wake), 64'(|(m_pend & m_wk)));
            check("R2 pin_oe vs model", 64'(pin_oe), m_dir & ((64'd1 << NP) - 1));
            check("R3 pin_out vs model", 64'(pin_out), m_drv & ((64'd1 << NP) - 1));
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [6:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(tag, 64'(bus_rdata), 64'(exp));
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset values
        rd("R1 dir low after reset", 7'h00, 32'h0);
        rd("R1 pending after reset", 7'h50, 32'h0);
        check("R1 irq after reset", 64'(irq), 64'(0));

        // R2: direction
        wr(7'h00, 32'h0000_00A5);
        check("R2 pin_oe low bits", 64'(pin_oe[7:0]), 64'hA5);
        rd("R2 dir readback", 7'h00, 32'h0000_00A5);

        // R5: high word, bits above NUM_PINS
        wr(7'h04, 32'hFFFF_FFFF);
        rd("R5 dir high word trimmed", 7'h04, 32'h0000_000F);
        check("R5 pin_oe high pins", 64'(pin_oe[35:32]), 64'hF);

        // R3: drive value
        wr(7'h18, 32'h1234_5678);
        check("R3 pin_out low", 64'(pin_out[31:0]), 64'h1234_5678);
        wr(7'h1C, 32'h0000_0003);
        rd("R3 drive high readback", 7'h1C, 32'h3);

        // R4 / R6: rising edges on pins 3 and 34, polarity 0
        pin_in[3] = 1'b1; pin_in[34] = 1'b1;
        tick();
        rd("R4 level after one edge", 7'h10, 32'h0);
        tick();
        rd("R4 level after two edges", 7'h10, 32'h8);
        rd("R4 level high word", 7'h14, 32'h4);
        rd("R6 pending not yet set", 7'h50, 32'h0);
        tick();
        rd("R6 rising sets pending low", 7'h50, 32'h8);
        rd("R6 rising sets pending high", 7'h54, 32'h4);
        check("R8 disabled pending gives no irq", 64'(irq), 64'(0));

        // R4: write to input word ignored
        wr(7'h10, 32'hFFFF_FFFF);
        rd("R4 input word write ignored", 7'h10, 32'h8);

        // R8: enable
        wr(7'h40, 32'h8);
        check("R8 irq after enable", 64'(irq), 64'(1));

        // R7: write 0 keeps, write 1 clears
        wr(7'h50, 32'h0);
        rd("R7 write zero keeps pending", 7'h50, 32'h8);
        wr(7'h50, 32'h8);
        rd("R7 write one clears", 7'h50, 32'h0);
        check("R8 irq drops after clear", 64'(irq), 64'(0));

        // R6: falling edge with polarity 1
        wr(7'h48, 32'h8);
        pin_in[3] = 1'b0;
        tick(); tick(); tick();
        rd("R6 falling sets pending", 7'h50, 32'h8);
        check("R8 irq on falling", 64'(irq), 64'(1));

        // R7: software flips polarity, new edge meets clearing write
        wr(7'h48, 32'h0);
        pin_in[3] = 1'b1;
        tick(); tick();
        wr(7'h50, 32'h8);
        rd("R7 edge wins over clear", 7'h50, 32'h8);
        wr(7'h50, 32'h8);
        rd("R7 later clear works", 7'h50, 32'h0);

        // R6: wrong direction sets nothing (pin 34 rising-only, falls)
        wr(7'h54, 32'h4);
        pin_in[34] = 1'b0;
        repeat (4) tick();
        rd("R6 falling ignored on rising pin", 7'h54, 32'h0);

        // R9: wake on pin 33 with interrupt disabled
        wr(7'h5C, 32'h2);
        pin_in[33] = 1'b1;
        tick(); tick(); tick();
        check("R9 wake raised", 64'(wake), 64'(1));
        check("R9 irq stays low", 64'(irq), 64'(0));
        wr(7'h54, 32'h2);
        check("R9 wake cleared", 64'(wake), 64'(0));

        tick();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

endmodule